// File: doc/BRIEF.md
# Fused multiply-add extended unit

This block multiplies two XLEN-bit operands, adds a third XLEN-bit operand and returns the whole double-width result as two XLEN-bit halves: the low half on one output and the high half on another. A follow-on step of a multi-word multiply can take the high half as its carry-in addend. No bits are lost to truncation. No flags are produced.

A single mode bit picks how the operands are read. In unsigned mode all three operands are plain unsigned numbers. In mixed mode the first multiplicand stays unsigned, while the second multiplicand and the addend are two's-complement signed values. The mixed product is built from an unsigned multiplier. The negative multiplicand is replaced by its magnitude, and the product is negated afterwards. No signed-by-unsigned multiplier cell is needed. The result is registered once. A request presented with `valid_i` appears on the outputs one clock later, together with `valid_o`.

Top module: `fmae_unit`

## Requirements
- R1: With `mode_i` = 0 (unsigned), the result is the full 2*XLEN-bit unsigned product of `a_i` and `b_i` plus the addend.
- R2: With `mode_i` = 0, `c_i` is zero-extended to 2*XLEN bits before the add, so an addend with its top bit set never makes the upper half all ones.
- R3: Bits XLEN-1..0 of the sum appear on `lo_o` and bits 2*XLEN-1..XLEN appear on `hi_o`.
- R4: With `mode_i` = 1 (mixed), `a_i` is unsigned and `b_i` is signed. The product equals `a_i` times the signed value of `b_i`, including `b_i` = 1 followed by XLEN-1 zeros.
- R5: With `mode_i` = 1, `c_i` is sign-extended from its top bit to 2*XLEN bits before the add.
- R6: `valid_o` is high in exactly the cycle after each cycle in which `valid_i` was sampled high, and results come out in request order.
- R7: While the active-low reset `rst_ni` is low, `valid_o`, `lo_o` and `hi_o` are 0.
- R8: The sum wraps modulo 2^(2*XLEN) and no overflow is signalled.
- R9: In a cycle where `valid_i` is low, `lo_o` and `hi_o` keep their previous values, whatever is on `a_i`, `b_i`, `c_i` and `mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = all unsigned, 1 = unsigned A, signed B and C |
| a_i | input | XLEN | First multiplicand, always unsigned |
| b_i | input | XLEN | Second multiplicand |
| c_i | input | XLEN | Addend |
| valid_i | input | 1 | Request strobe |
| lo_o | output | XLEN | Low half of the sum |
| hi_o | output | XLEN | High half of the sum |
| valid_o | output | 1 | Result strobe |

## Verification
All-ones operands with an all-ones addend in unsigned mode reach the largest sum that still fits, so they expose a dropped carry between the halves. Mixed mode is driven with the most negative `b_i` and with `b_i` = -1 against a full-scale `a_i`, which separates true sign handling from a plain unsigned multiply. Negative addends in mixed mode, against an unsigned addend with its top bit set, distinguish sign extension from zero extension. Streams of random requests in both modes, with mode changes back to back and idle gaps filled with junk inputs, check ordering, latency and result hold.

// File: rtl/fmae_pkg.sv
package fmae_pkg;

    typedef enum logic {
        FMAE_UNSIGNED = 1'b0,
        FMAE_MIXED    = 1'b1
    } fmae_mode_e;

endpackage

// File: rtl/fmae_operand_prep.sv
module fmae_operand_prep
    import fmae_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  fmae_mode_e          mode_i,
    input  logic [XLEN-1:0]     b_i,
    input  logic [XLEN-1:0]     c_i,
    output logic [XLEN-1:0]     b_mag_o,
    output logic                neg_o,
    output logic [2*XLEN-1:0]   c_ext_o
);

    localparam int MSB = XLEN - 1;

    logic c_fill;

    always_comb begin
        // B is a signed value only in mixed mode; take its magnitude
        neg_o   = (mode_i == FMAE_MIXED) && b_i[MSB];
        b_mag_o = neg_o ? (~b_i + {{(XLEN-1){1'b0}}, 1'b1}) : b_i;
        // Addend extension: sign bit in mixed mode, zero otherwise
        c_fill  = (mode_i == FMAE_MIXED) && c_i[MSB];
        c_ext_o = {{XLEN{c_fill}}, c_i};
    end

endmodule

// File: rtl/fmae_mul_core.sv
module fmae_mul_core #(
    parameter int XLEN = 64
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [XLEN-1:0]     a_i,
    input  logic [XLEN-1:0]     b_mag_i,
    input  logic                neg_i,
    output logic [2*XLEN-1:0]   prod_o
);

    localparam int PW = 2 * XLEN;

    logic [PW-1:0] a_wide;
    logic [PW-1:0] b_wide;
    logic [PW-1:0] mag_prod;

    always_comb begin
        a_wide   = {{XLEN{1'b0}}, a_i};
        b_wide   = {{XLEN{1'b0}}, b_mag_i};
        mag_prod = a_wide * b_wide;
        prod_o   = neg_i ? (~mag_prod + {{(PW-1){1'b0}}, 1'b1}) : mag_prod;
    end

    // R1: a zero operand gives a zero product in either sign case
    p_zero_operand_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((a_i == '0) || (b_mag_i == '0)) |-> (prod_o == '0));

    // R4: a negative multiplicand never arrives with zero magnitude
    p_neg_magnitude_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        neg_i |-> (b_mag_i != '0));

endmodule

// File: rtl/fmae_sum.sv
module fmae_sum #(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0]   prod_i,
    input  logic [2*XLEN-1:0]   c_ext_i,
    output logic [XLEN-1:0]     lo_o,
    output logic [XLEN-1:0]     hi_o
);

    logic [2*XLEN-1:0] total;

    always_comb begin
        total = prod_i + c_ext_i;   // wraps modulo 2^(2*XLEN)
        lo_o  = total[XLEN-1:0];
        hi_o  = total[2*XLEN-1:XLEN];
    end

endmodule

// File: rtl/fmae_unit.sv
module fmae_unit
    import fmae_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                mode_i,
    input  logic [XLEN-1:0]     a_i,
    input  logic [XLEN-1:0]     b_i,
    input  logic [XLEN-1:0]     c_i,
    input  logic                valid_i,
    output logic [XLEN-1:0]     lo_o,
    output logic [XLEN-1:0]     hi_o,
    output logic                valid_o
);

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] lo;
        logic [XLEN-1:0] hi;
    } fmae_state_t;

    fmae_mode_e        mode;
    logic [XLEN-1:0]   b_mag;
    logic              b_neg;
    logic [2*XLEN-1:0] c_ext;
    logic [2*XLEN-1:0] prod;
    logic [XLEN-1:0]   sum_lo;
    logic [XLEN-1:0]   sum_hi;

    fmae_state_t state_d, state_q;

    assign mode = fmae_mode_e'(mode_i);

    fmae_operand_prep #(.XLEN(XLEN)) u_prep (
        .mode_i  (mode),
        .b_i     (b_i),
        .c_i     (c_i),
        .b_mag_o (b_mag),
        .neg_o   (b_neg),
        .c_ext_o (c_ext)
    );

    fmae_mul_core #(.XLEN(XLEN)) u_mul (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .a_i     (a_i),
        .b_mag_i (b_mag),
        .neg_i   (b_neg),
        .prod_o  (prod)
    );

    fmae_sum #(.XLEN(XLEN)) u_sum (
        .prod_i  (prod),
        .c_ext_i (c_ext),
        .lo_o    (sum_lo),
        .hi_o    (sum_hi)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = valid_i;
        if (valid_i) begin
            state_d.lo = sum_lo;
            state_d.hi = sum_hi;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lo_o    = state_q.lo;
    assign hi_o    = state_q.hi;
    assign valid_o = state_q.vld;

    // R6: one-cycle latency from request to result strobe
    p_valid_follows_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);
    p_no_spurious_valid_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o);

    // R9: idle cycles leave the result registers untouched
    p_hold_when_idle_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ($stable(lo_o) && $stable(hi_o)));

    // R2: unsigned mode never feeds sign bits into the upper addend half
    p_zero_extend_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && (mode == FMAE_UNSIGNED)) |-> (c_ext[2*XLEN-1:XLEN] == '0));

endmodule

// File: tb/fmae_unit_bench.sv
module fmae_unit_bench;

    localparam int X = 64;
    localparam logic [X-1:0] ONES = '1;
    localparam logic [X-1:0] MINV = {1'b1, {(X-1){1'b0}}};

    typedef struct {
        logic [X-1:0] lo;
        logic [X-1:0] hi;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode = 1'b0;
    logic [X-1:0] a = '0, b = '0, c = '0;
    logic         vin = 1'b0;
    logic [X-1:0] lo, hi;
    logic         vout;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    bit   have_last = 1'b0;
    logic [X-1:0] last_lo, last_hi;
    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    fmae_unit #(.XLEN(X)) u_fmae_unit (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
        .a_i(a), .b_i(b), .c_i(c), .valid_i(vin),
        .lo_o(lo), .hi_o(hi), .valid_o(vout)
    );

    function automatic logic [2*X-1:0] model(logic m, logic [X-1:0] fa,
                                             logic [X-1:0] fb, logic [X-1:0] fc);
        logic [2*X-1:0] ax, bx, cx;
        ax = {{X{1'b0}}, fa};
        bx = {{X{m & fb[X-1]}}, fb};
        cx = {{X{m & fc[X-1]}}, fc};
        return ax * bx + cx;
    endfunction

    function automatic logic [X-1:0] rnd();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check(string tag, logic [X-1:0] act, logic [X-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(logic m, logic [X-1:0] fa, logic [X-1:0] fb,
                        logic [X-1:0] fc, string tag);
        logic [2*X-1:0] r;
        exp_t e;
        @(negedge clk);
        mode = m; a = fa; b = fb; c = fc; vin = 1'b1;
        r = model(m, fa, fb, fc);
        e.lo = r[X-1:0];
        e.hi = r[2*X-1:X];
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vin = 1'b0; mode = $urandom_range(1); a = rnd(); b = rnd(); c = rnd();
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (vout) begin
                if (q.size() == 0) begin
                    check("R6 unexpected valid_o", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.tag, " R3 lo"}, lo, e.lo);
                    check({e.tag, " R3 hi"}, hi, e.hi);
                end
                last_lo = lo; last_hi = hi; have_last = 1'b1;
            end else if (have_last) begin
                check("R9 hold lo", lo, last_lo);
                check("R9 hold hi", hi, last_hi);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset valid_o", {63'd0, vout}, '0);
        check("R7 reset lo_o", lo, '0);
        check("R7 reset hi_o", hi, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        send(1'b0, ONES, ONES, '0,   "R1 unsigned max product");
        send(1'b0, ONES, ONES, ONES, "R8 unsigned all ones");
        send(1'b0, '0, '0, MINV | 64'd1, "R2 zero-extended addend");
        send(1'b0, 64'd7, 64'd9, ONES, "R2 carry into high half");
        idle(3);
        send(1'b1, 64'd3, MINV, '0, "R4 most negative B");
        send(1'b1, ONES, MINV, ONES, "R4 most negative B, full A");
        send(1'b1, ONES, ONES, '0, "R4 B minus one");
        send(1'b1, 64'd5, 64'd7, -64'd10, "R5 negative addend");
        send(1'b1, ONES, ONES, ONES, "R8 mixed wrap");
        send(1'b1, MINV, 64'h7FFF_FFFF_FFFF_FFFF, MINV, "R5 positive B, min C");
        send(1'b0, 64'd5, 64'd7, -64'd10, "R2 same operands unsigned");
        idle(4);
        for (int i = 0; i < 40; i++) begin
            send(i[0], rnd(), rnd(), rnd(), "R6 random stream");
            if (i % 9 == 8) idle(2);
        end
        idle(5);
        check("R6 all results returned", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule